// File: doc/BRIEF.md
# Multi-Cycle Processor Control Sequencer

This block is the control state machine of a 16-bit load/store processor that fetches instructions and data through one shared memory port and keeps eight general registers. It reads the 4-bit opcode held in the instruction register and the zero and negative flags from the ALU. Its outputs steer the datapath: the two ALU operand selects, the ALU operation, the PC enables and PC source, the memory direction, address source and write-data source, the register-file destination, write enable and write-back source, the immediate width, and the half chosen by the load-immediate unit.

Every instruction spends one cycle in FETCH and one in DECODE. Most then finish in a single execute state, because results are written straight into the synchronous register file with no holding register in between. Loads and stores take one more cycle. A NOP leaves DECODE and goes straight back to FETCH. A reserved opcode makes the sequencer store the address of the faulting instruction at 0xFFFF and then stop in a halt state until reset. The sequencer also merges the unconditional PC enable with the conditional one and the selected flag into a single PC update strobe.

States are FETCH, DECODE, MEM_ADDR, LOAD, STORE, ALU_REG, ADD_IMM, AND_IMM, LI_HIGH, LI_LOW, BR_LT, BR_EQ, JUMP_LINK, JUMP_REG, FAULT_SAVE and HALT. The transitions are:
- FETCH→DECODE
- DECODE→FETCH (NOP), →ALU_REG, →ADD_IMM, →AND_IMM, →MEM_ADDR (load or store), →LI_HIGH, →LI_LOW, →BR_LT, →BR_EQ, →JUMP_LINK, →JUMP_REG, →FAULT_SAVE (reserved)
- MEM_ADDR→LOAD or →STORE
- FAULT_SAVE→HALT, HALT→HALT
- every other state →FETCH

Top module: `cpu_ctl_fsm`

## Requirements
- R1: A synchronous active-high reset puts the sequencer in FETCH, so the first cycle after reset shows the FETCH outputs.
- R2: FETCH drives ALU A=PC (0), ALU B=2'b01 (constant 1), ALU op=2'b00 (ADD), address select=2'b00 (PC), memory read=1, PC source=2'b00 (PC+1), PC write=1 and IR write=1. The next state is always DECODE.
- R3: DECODE drives ALU A=PC, ALU B=2'b10 (immediate), ALU op=ADD and immediate width=1 (8-bit), which precomputes the branch target. It dispatches on opcode bits 15:12 as follows: 0 NOP, 1 R-type, 2 ADDI, 3 ANDI, 4 LW, 5 SW, 6 LIH, 7 LIL, 8 BLT, 9 BEQ, 10 JAL, 11 JR, 12 to 15 reserved. A NOP goes back to FETCH.
- R4: ALU_REG drives ALU A=register (1), ALU B=2'b00 (register), ALU op=2'b11 (function field), destination=2'b00, write-back=2'b00 (ALU) and register write=1.
- R5: ADD_IMM and AND_IMM drive ALU A=register, ALU B=immediate, immediate width=0 (6-bit), destination=2'b01, write-back=ALU and register write. The ALU op is 2'b00 (ADD) for ADD_IMM and 2'b10 (AND) for AND_IMM.
- R6: Loads and stores first pass through MEM_ADDR (ALU A=register, ALU B=immediate, width 0, ADD). A load then enters LOAD (address select=2'b01, memory read=1, destination=2'b10, write-back=2'b01 memory, register write=1). A store enters STORE (address select=2'b01, memory read=0, write data=0 register).
- R7: LI_HIGH and LI_LOW drive write-back=2'b10 (load-immediate unit), destination=2'b01 and register write=1. The half select is 0 (upper byte) in LI_HIGH and 1 (lower byte) in LI_LOW.
- R8: BR_LT and BR_EQ drive ALU A=register, ALU B=2'b11 (constant 0), ADD, conditional PC write=1 and PC source=2'b01 (branch target). The flag select is 0 (negative) in BR_LT and 1 (zero) in BR_EQ. The PC update strobe follows the selected flag.
- R9: JUMP_LINK drives ALU A=PC, ALU B=constant 0, ADD, destination=2'b10, write-back=ALU, register write=1, PC source=2'b10 (register) and PC write=1. JUMP_REG drives only PC source=2'b10 and PC write=1 (with memory read).
- R10: A reserved opcode enters FAULT_SAVE (ALU A=PC, ALU B=constant 1, ALU op=2'b01 SUB, address select=2'b10 constant 0xFFFF, memory read=0, write data=1 ALU) and then HALT. In HALT every output is 0 except memory read=1. HALT ignores the opcode and holds until reset.
- R11: Each execute state except MEM_ADDR and FAULT_SAVE returns to FETCH on the next cycle. The PC update strobe equals PC write in every state other than the two branch states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 4 | Opcode field (instruction bits 15:12) from the instruction register |
| flag_zero | input | 1 | ALU result is zero |
| flag_neg | input | 1 | ALU result is negative |
| alu_a_sel | output | 1 | ALU A: 0 PC, 1 register |
| alu_b_sel | output | 2 | ALU B: 00 register, 01 one, 10 immediate, 11 zero |
| alu_op | output | 2 | 00 ADD, 01 SUB, 10 AND, 11 function field |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | Conditional PC write |
| pc_src | output | 2 | 00 PC+1, 01 branch target, 10 register, 11 zero |
| mem_rd | output | 1 | 1 read, 0 write |
| addr_sel | output | 2 | 00 PC, 01 ALU, 10 0xFFFF |
| mem_data_sel | output | 1 | Store data: 0 register, 1 ALU |
| reg_dst | output | 2 | Destination register field select |
| reg_wr | output | 1 | Register file write enable |
| wb_sel | output | 2 | 00 ALU, 01 memory, 10 load-immediate |
| imm_wide | output | 1 | 0 six-bit, 1 eight-bit immediate |
| lim_low | output | 1 | Load-immediate half: 0 upper, 1 lower |
| ir_wr | output | 1 | Instruction register write |
| br_on_zero | output | 1 | Branch flag: 0 negative, 1 zero |
| pc_update | output | 1 | Final PC enable |

## Verification
The assertions assume that the opcode stays stable from DECODE through the last execute state of an instruction, as it does when it comes from a held instruction register. They also assume that reset is asserted from time zero. The scoreboard driver sets a new opcode only on the falling edge that opens a FETCH cycle, and sets the flags together with the opcode. In HALT it then deliberately changes the opcode to show that the state does not follow it. Reset is held for several cycles at the start and applied again mid-run to leave HALT.

// File: rtl/cpu_ctl_pkg.sv
package cpu_ctl_pkg;

    localparam int OPC_W = 4;

    typedef enum logic [3:0] {
        ST_FETCH, ST_DECODE, ST_MEM_ADDR, ST_LOAD,
        ST_STORE, ST_ALU_REG, ST_ADD_IMM, ST_AND_IMM,
        ST_LI_HIGH, ST_LI_LOW, ST_BR_LT, ST_BR_EQ,
        ST_JUMP_LINK, ST_JUMP_REG, ST_FAULT_SAVE, ST_HALT
    } state_t;

    typedef enum logic [OPC_W-1:0] {
        OP_NOP  = 4'd0,  OP_RTYPE = 4'd1,  OP_ADDI = 4'd2,  OP_ANDI = 4'd3,
        OP_LW   = 4'd4,  OP_SW    = 4'd5,  OP_LIH  = 4'd6,  OP_LIL  = 4'd7,
        OP_BLT  = 4'd8,  OP_BEQ   = 4'd9,  OP_JAL  = 4'd10, OP_JR   = 4'd11
    } opc_t;

    typedef struct packed {
        logic       alu_a_sel;
        logic [1:0] alu_b_sel;
        logic [1:0] alu_op;
        logic       pc_wr;
        logic       pc_wr_cond;
        logic [1:0] pc_src;
        logic       mem_rd;
        logic [1:0] addr_sel;
        logic       mem_data_sel;
        logic [1:0] reg_dst;
        logic       reg_wr;
        logic [1:0] wb_sel;
        logic       imm_wide;
        logic       lim_low;
        logic       ir_wr;
        logic       br_on_zero;
    } ctl_t;

endpackage

// File: rtl/cpu_ctl_dispatch.sv
module cpu_ctl_dispatch
    import cpu_ctl_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output state_t           exec_state
);
    always_comb begin
        unique case (opcode)
            OP_NOP:   exec_state = ST_FETCH;
            OP_RTYPE: exec_state = ST_ALU_REG;
            OP_ADDI:  exec_state = ST_ADD_IMM;
            OP_ANDI:  exec_state = ST_AND_IMM;
            OP_LW,
            OP_SW:    exec_state = ST_MEM_ADDR;
            OP_LIH:   exec_state = ST_LI_HIGH;
            OP_LIL:   exec_state = ST_LI_LOW;
            OP_BLT:   exec_state = ST_BR_LT;
            OP_BEQ:   exec_state = ST_BR_EQ;
            OP_JAL:   exec_state = ST_JUMP_LINK;
            OP_JR:    exec_state = ST_JUMP_REG;
            default:  exec_state = ST_FAULT_SAVE;
        endcase
    end
endmodule

// File: rtl/cpu_ctl_state.sv
module cpu_ctl_state
    import cpu_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opcode,
    input  state_t           exec_state,
    output state_t           state_q
);
    state_t state_d;

    always_comb begin
        unique case (state_q)
            ST_FETCH:      state_d = ST_DECODE;
            ST_DECODE:     state_d = exec_state;
            ST_MEM_ADDR:   state_d = (opcode == OP_LW) ? ST_LOAD : ST_STORE;
            ST_FAULT_SAVE: state_d = ST_HALT;
            ST_HALT:       state_d = ST_HALT;
            default:       state_d = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FETCH;
        else     state_q <= state_d;
    end
endmodule

// File: rtl/cpu_ctl_outputs.sv
module cpu_ctl_outputs
    import cpu_ctl_pkg::*;
(
    input  state_t state_q,
    output ctl_t   ctl
);
    always_comb begin
        ctl        = '0;
        ctl.mem_rd = 1'b1;
        unique case (state_q)
            ST_FETCH: begin
                ctl.alu_b_sel = 2'b01;
                ctl.pc_wr     = 1'b1;
                ctl.ir_wr     = 1'b1;
            end
            ST_DECODE: begin
                ctl.alu_b_sel = 2'b10;
                ctl.imm_wide  = 1'b1;
            end
            ST_MEM_ADDR: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_b_sel = 2'b10;
            end
            ST_LOAD: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_b_sel = 2'b10;
                ctl.addr_sel  = 2'b01;
                ctl.reg_dst   = 2'b10;
                ctl.wb_sel    = 2'b01;
                ctl.reg_wr    = 1'b1;
            end
            ST_STORE: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_b_sel = 2'b10;
                ctl.addr_sel  = 2'b01;
                ctl.mem_rd    = 1'b0;
            end
            ST_ALU_REG: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_op    = 2'b11;
                ctl.reg_wr    = 1'b1;
            end
            ST_ADD_IMM, ST_AND_IMM: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_b_sel = 2'b10;
                ctl.alu_op    = (state_q == ST_AND_IMM) ? 2'b10 : 2'b00;
                ctl.reg_dst   = 2'b01;
                ctl.reg_wr    = 1'b1;
            end
            ST_LI_HIGH, ST_LI_LOW: begin
                ctl.wb_sel    = 2'b10;
                ctl.reg_dst   = 2'b01;
                ctl.reg_wr    = 1'b1;
                ctl.lim_low   = (state_q == ST_LI_LOW);
            end
            ST_BR_LT, ST_BR_EQ: begin
                ctl.alu_a_sel  = 1'b1;
                ctl.alu_b_sel  = 2'b11;
                ctl.pc_wr_cond = 1'b1;
                ctl.pc_src     = 2'b01;
                ctl.br_on_zero = (state_q == ST_BR_EQ);
            end
            ST_JUMP_LINK: begin
                ctl.alu_b_sel = 2'b11;
                ctl.reg_dst   = 2'b10;
                ctl.reg_wr    = 1'b1;
                ctl.pc_src    = 2'b10;
                ctl.pc_wr     = 1'b1;
            end
            ST_JUMP_REG: begin
                ctl.pc_src    = 2'b10;
                ctl.pc_wr     = 1'b1;
            end
            ST_FAULT_SAVE: begin
                ctl.alu_b_sel    = 2'b01;
                ctl.alu_op       = 2'b01;
                ctl.addr_sel     = 2'b10;
                ctl.mem_rd       = 1'b0;
                ctl.mem_data_sel = 1'b1;
            end
            ST_HALT: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/cpu_ctl_fsm.sv
module cpu_ctl_fsm
    import cpu_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] opcode,
    input  logic       flag_zero,
    input  logic       flag_neg,
    output logic       alu_a_sel,
    output logic [1:0] alu_b_sel,
    output logic [1:0] alu_op,
    output logic       pc_wr,
    output logic       pc_wr_cond,
    output logic [1:0] pc_src,
    output logic       mem_rd,
    output logic [1:0] addr_sel,
    output logic       mem_data_sel,
    output logic [1:0] reg_dst,
    output logic       reg_wr,
    output logic [1:0] wb_sel,
    output logic       imm_wide,
    output logic       lim_low,
    output logic       ir_wr,
    output logic       br_on_zero,
    output logic       pc_update
);
    state_t state_q;
    state_t exec_state;
    ctl_t   ctl;

    cpu_ctl_dispatch u_dispatch (.opcode(opcode), .exec_state(exec_state));

    cpu_ctl_state u_state (
        .clk(clk), .rst(rst), .opcode(opcode),
        .exec_state(exec_state), .state_q(state_q)
    );

    cpu_ctl_outputs u_outputs (.state_q(state_q), .ctl(ctl));

    assign alu_a_sel    = ctl.alu_a_sel;
    assign alu_b_sel    = ctl.alu_b_sel;
    assign alu_op       = ctl.alu_op;
    assign pc_wr        = ctl.pc_wr;
    assign pc_wr_cond   = ctl.pc_wr_cond;
    assign pc_src       = ctl.pc_src;
    assign mem_rd       = ctl.mem_rd;
    assign addr_sel     = ctl.addr_sel;
    assign mem_data_sel = ctl.mem_data_sel;
    assign reg_dst      = ctl.reg_dst;
    assign reg_wr       = ctl.reg_wr;
    assign wb_sel       = ctl.wb_sel;
    assign imm_wide     = ctl.imm_wide;
    assign lim_low      = ctl.lim_low;
    assign ir_wr        = ctl.ir_wr;
    assign br_on_zero   = ctl.br_on_zero;
    assign pc_update    = ctl.pc_wr |
                          (ctl.pc_wr_cond & (ctl.br_on_zero ? flag_zero : flag_neg));
endmodule

// File: rtl/cpu_ctl_checker.sv
module cpu_ctl_checker
    import cpu_ctl_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input state_t     state_q,
    input logic       ir_wr,
    input logic       imm_wide,
    input logic [1:0] alu_b_sel,
    input logic       pc_wr_cond,
    input logic       reg_wr,
    input logic       mem_rd,
    input logic [1:0] addr_sel
);
    // R10: once halted, the state never leaves HALT without reset
    assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_HALT |=> state_q == ST_HALT);

    // R10: the fault write to 0xFFFF is followed by HALT
    assert_fault_then_halt_R10: assert property (@(posedge clk) disable iff (rst)
        (!mem_rd && addr_sel == 2'b10) |=> state_q == ST_HALT);

    // R2/R3: a fetch cycle is followed by a decode cycle
    assert_fetch_then_decode_R2: assert property (@(posedge clk) disable iff (rst)
        ir_wr |=> (!ir_wr && alu_b_sel == 2'b10 && imm_wide));

    // R11: a branch state returns to fetch
    assert_branch_returns_R11: assert property (@(posedge clk) disable iff (rst)
        pc_wr_cond |=> ir_wr);

    // R11: a register-writing execute state returns to fetch
    assert_writeback_returns_R11: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> ir_wr);

    // R6: a store cycle returns to fetch
    assert_store_returns_R6: assert property (@(posedge clk) disable iff (rst)
        (!mem_rd && addr_sel == 2'b01) |=> ir_wr);
endmodule

bind cpu_ctl_fsm cpu_ctl_checker u_checker (
    .clk(clk), .rst(rst), .state_q(state_q), .ir_wr(ir_wr),
    .imm_wide(imm_wide), .alu_b_sel(alu_b_sel), .pc_wr_cond(pc_wr_cond),
    .reg_wr(reg_wr), .mem_rd(mem_rd), .addr_sel(addr_sel)
);

// File: tb/cpu_ctl_fsm_bench.sv
module cpu_ctl_fsm_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] opcode;
    logic       flag_zero, flag_neg;
    logic       alu_a_sel, pc_wr, pc_wr_cond, mem_rd, mem_data_sel, reg_wr;
    logic       imm_wide, lim_low, ir_wr, br_on_zero, pc_update;
    logic [1:0] alu_b_sel, alu_op, pc_src, addr_sel, reg_dst, wb_sel;

    int checks = 0;
    int errors = 0;
    logic [22:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    cpu_ctl_fsm u_cpu_ctl_fsm (
        .clk(clk), .rst(rst), .opcode(opcode), .flag_zero(flag_zero), .flag_neg(flag_neg),
        .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_op(alu_op), .pc_wr(pc_wr),
        .pc_wr_cond(pc_wr_cond), .pc_src(pc_src), .mem_rd(mem_rd), .addr_sel(addr_sel),
        .mem_data_sel(mem_data_sel), .reg_dst(reg_dst), .reg_wr(reg_wr), .wb_sel(wb_sel),
        .imm_wide(imm_wide), .lim_low(lim_low), .ir_wr(ir_wr), .br_on_zero(br_on_zero),
        .pc_update(pc_update)
    );

    // expected-state identifiers, bench-local
    localparam int E_FETCH = 0, E_DECODE = 1, E_ADDR = 2, E_LOAD = 3, E_STORE = 4,
                   E_ALU = 5, E_ADDI = 6, E_ANDI = 7, E_LIH = 8, E_LIL = 9,
                   E_BLT = 10, E_BEQ = 11, E_JAL = 12, E_JR = 13, E_FAULT = 14, E_HALT = 15;

    // field order: a b op pcw cond src rd addr md dst rw wb iw lo ir bz upd
    function automatic logic [22:0] vec(logic a, logic [1:0] b, logic [1:0] op, logic pcw,
            logic cond, logic [1:0] src, logic rd, logic [1:0] ad, logic md, logic [1:0] dst,
            logic rw, logic [1:0] wb, logic iw, logic lo, logic ir, logic bz, logic upd);
        return {a, b, op, pcw, cond, src, rd, ad, md, dst, rw, wb, iw, lo, ir, bz, upd};
    endfunction

    function automatic logic [22:0] expect_of(int id, logic z, logic n);
        case (id)
            E_FETCH:  return vec(0,2'b01,2'b00,1,0,2'b00,1,2'b00,0,2'b00,0,2'b00,0,0,1,0,1);
            E_DECODE: return vec(0,2'b10,2'b00,0,0,2'b00,1,2'b00,0,2'b00,0,2'b00,1,0,0,0,0);
            E_ADDR:   return vec(1,2'b10,2'b00,0,0,2'b00,1,2'b00,0,2'b00,0,2'b00,0,0,0,0,0);
            E_LOAD:   return vec(1,2'b10,2'b00,0,0,2'b00,1,2'b01,0,2'b10,1,2'b01,0,0,0,0,0);
            E_STORE:  return vec(1,2'b10,2'b00,0,0,2'b00,0,2'b01,0,2'b00,0,2'b00,0,0,0,0,0);
            E_ALU:    return vec(1,2'b00,2'b11,0,0,2'b00,1,2'b00,0,2'b00,1,2'b00,0,0,0,0,0);
            E_ADDI:   return vec(1,2'b10,2'b00,0,0,2'b00,1,2'b00,0,2'b01,1,2'b00,0,0,0,0,0);
            E_ANDI:   return vec(1,2'b10,2'b10,0,0,2'b00,1,2'b00,0,2'b01,1,2'b00,0,0,0,0,0);
            E_LIH:    return vec(0,2'b00,2'b00,0,0,2'b00,1,2'b00,0,2'b01,1,2'b10,0,0,0,0,0);
            E_LIL:    return vec(0,2'b00,2'b00,0,0,2'b00,1,2'b00,0,2'b01,1,2'b10,0,1,0,0,0);
            E_BLT:    return vec(1,2'b11,2'b00,0,1,2'b01,1,2'b00,0,2'b00,0,2'b00,0,0,0,0,n);
            E_BEQ:    return vec(1,2'b11,2'b00,0,1,2'b01,1,2'b00,0,2'b00,0,2'b00,0,0,0,1,z);
            E_JAL:    return vec(0,2'b11,2'b00,1,0,2'b10,1,2'b00,0,2'b10,1,2'b00,0,0,0,0,1);
            E_JR:     return vec(0,2'b00,2'b00,1,0,2'b10,1,2'b00,0,2'b00,0,2'b00,0,0,0,0,1);
            E_FAULT:  return vec(0,2'b01,2'b01,0,0,2'b00,0,2'b10,1,2'b00,0,2'b00,0,0,0,0,0);
            default:  return vec(0,2'b00,2'b00,0,0,2'b00,1,2'b00,0,2'b00,0,2'b00,0,0,0,0,0);
        endcase
    endfunction

    function automatic logic [22:0] actual();
        return {alu_a_sel, alu_b_sel, alu_op, pc_wr, pc_wr_cond, pc_src, mem_rd, addr_sel,
                mem_data_sel, reg_dst, reg_wr, wb_sel, imm_wide, lim_low, ir_wr, br_on_zero,
                pc_update};
    endfunction

    task automatic push(int id, string tag);
        exp_q.push_back(expect_of(id, flag_zero, flag_neg));
        tag_q.push_back(tag);
    endtask

    // driver: called on a falling edge that opens a FETCH cycle
    task automatic issue(logic [3:0] op, logic z, logic n, string tag);
        int len;
        opcode = op; flag_zero = z; flag_neg = n;
        push(E_FETCH, "R2"); push(E_DECODE, "R3");
        len = 3;
        case (op)
            4'd0:  len = 2;
            4'd1:  push(E_ALU, tag);
            4'd2:  push(E_ADDI, tag);
            4'd3:  push(E_ANDI, tag);
            4'd4:  begin push(E_ADDR, tag); push(E_LOAD, tag);  len = 4; end
            4'd5:  begin push(E_ADDR, tag); push(E_STORE, tag); len = 4; end
            4'd6:  push(E_LIH, tag);
            4'd7:  push(E_LIL, tag);
            4'd8:  push(E_BLT, tag);
            4'd9:  push(E_BEQ, tag);
            4'd10: push(E_JAL, tag);
            4'd11: push(E_JR, tag);
            default: len = 2;
        endcase
        repeat (len) @(negedge clk);
    endtask

    // monitor: compares one expected item per cycle, just after the falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (!rst && exp_q.size() > 0) begin
                logic [22:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (actual() !== e) begin
                    errors++;
                    $display("FAIL %s: actual %b expected %b", t, actual(), e);
                end
            end
        end
    end

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; opcode = 4'd0; flag_zero = 1'b0; flag_neg = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        checks++;
        if (actual() !== expect_of(E_FETCH, 0, 0)) begin
            errors++;
            $display("FAIL R1: actual %b expected %b", actual(), expect_of(E_FETCH, 0, 0));
        end
        @(negedge clk);
        rst = 1'b0;
        issue(4'd0,  0, 0, "R3");   // NOP
        issue(4'd1,  0, 0, "R4");
        issue(4'd2,  0, 0, "R5");
        issue(4'd3,  0, 0, "R5");
        issue(4'd4,  0, 0, "R6");
        issue(4'd5,  0, 0, "R6");
        issue(4'd6,  0, 0, "R7");
        issue(4'd7,  0, 0, "R7");
        issue(4'd8,  0, 1, "R8");   // BLT taken
        issue(4'd8,  1, 0, "R8");   // BLT not taken, zero ignored
        issue(4'd9,  1, 0, "R8");   // BEQ taken
        issue(4'd9,  0, 1, "R8");   // BEQ not taken, neg ignored
        issue(4'd10, 1, 1, "R9");
        issue(4'd11, 0, 0, "R9");
        issue(4'd0,  1, 1, "R11");  // flags high, NOP: strobe follows pc_wr only
        // R10: reserved opcode, fault save then sticky halt
        opcode = 4'd13; flag_zero = 1'b1; flag_neg = 1'b1;
        push(E_FETCH, "R2"); push(E_DECODE, "R3");
        push(E_FAULT, "R10"); push(E_HALT, "R10");
        repeat (3) @(negedge clk);
        opcode = 4'd1;
        @(negedge clk);
        for (int k = 0; k < 4; k++) push(E_HALT, "R10");
        repeat (4) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        issue(4'd12, 0, 0, "R10");  // after reset: FETCH, DECODE, then fault again
        push(E_FAULT, "R10"); push(E_HALT, "R1");
        repeat (2) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        issue(4'd4, 0, 0, "R1");
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule